// File: doc/BRIEF.md
# Byte-Wide SPI Slave with Flag-Clearing Handshake

This block is the receive and transmit engine for an 8-bit SPI slave that sits on a processor's register bus. An external master supplies the serial clock, the active-low select and the MOSI data. The block returns one byte per transfer on MISO, most significant bit first. The serial inputs pass through two-flop synchronizers, and all edge detection runs on the system clock. That clock must run at least four times faster than the serial clock.

Software loads the next outgoing byte by writing the data register. When a byte completes, the incoming byte is copied into a receive buffer, and reads of the data register return that buffer. A completion flag is raised at the same time. Software clears the flag in two steps: it reads the status register while a flag is up, then it reads the data register. A write to the data register while the completion flag is up is ignored until the status read has taken place. If a second byte completes before the flag is cleared, an overrun is recorded. A data-register write made while a byte is moving is a write collision; so is one made in phase-0 mode while the select is low. The block raises an interrupt request for the completion flag, gated by an enable bit and by an external mask.

Top module: `spi_slave_hs`

## Requirements
- R1: After reset the status register reads 0x00, the data register reads 0x00, irq_o is low and miso_o is low.
- R2: The master's byte is captured MSB first. When the eighth sampling edge is seen, it is placed in the receive buffer, which bus_sel=1 reads, and the completion flag (status bit 7) is set.
- R3: A byte written with bus_sel=1 while the block is idle is sent on miso_o MSB first. In phase-0 mode the MSB is driven as soon as the select falls, and miso_o is low whenever the select is high.
- R4: All four mode combinations of cfg_cpol and cfg_cpha move data correctly. Phase 0 samples on the leading edge of the serial clock and phase 1 on the trailing edge. Polarity 1 idles the clock high.
- R5: The completion flag stays set until a status read (bus_sel=0) made while a flag is set is followed by a data read. A data read with no such status read first leaves the flag set.
- R6: A data-register write made while the completion flag is set, before any status read, is ignored.
- R7: If a byte completes while the completion flag is still set, the overrun bit (status bit 5) is set and the receive buffer keeps the earlier byte. The overrun bit is cleared by the same status-then-data read sequence.
- R8: A data-register write made during an active shift, or made in phase-0 mode while the select is low, sets the collision bit (status bit 6) and the written byte is discarded. A status read followed by a data access clears the bit.
- R9: irq_o is high exactly when the completion flag is set, cfg_irq_en is 1 and irq_mask_i is 0.
- R10: With cfg_en low, serial clock activity is ignored: no flag is set and miso_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master, low while deselected |
| cfg_en | input | 1 | Block enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Sampling edge: 0 leading, 1 trailing |
| irq_mask_i | input | 1 | Global interrupt mask, 1 blocks irq_o |
| bus_sel | input | 1 | Register select: 0 status, 1 data |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bit counter or a wrong edge choice shows up on the master's side within one byte: the captured MISO value or the byte read from the data register is shifted or rotated. A broken clearing handshake shows on the first status read after the next access. Either the flag survives a proper sequence, or it vanishes after a bare data read. A wrong decision on writes shows one transfer later, when the following byte on MISO carries the blocked or colliding value instead of the expected one. Wrong overrun handling shows on the next read of the data register, which returns the newer byte.

// File: rtl/spis_pkg.sv
package spis_pkg;

    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_DATA   = 1'b1;

    typedef struct packed {
        logic spif;
        logic wcol;
        logic ovr;
    } spis_flags_t;

endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int            W       = 3,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/spis_shift.sv
module spis_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          sck_s,
    input  logic          ss_n_s,
    input  logic          mosi_s,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    output logic          miso,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_data
);

    localparam int CNT_W = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1);

    typedef struct packed {
        logic             sck_p;
        logic             ss_p;
        logic [DW-1:0]    shreg;
        logic [DW-1:0]    rxsh;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             miso;
    } sh_t;

    sh_t q, d;

    logic rise, fall, lead, trail, active, samp, drv, ss_fall;

    always_comb begin
        rise    = sck_s & ~q.sck_p;
        fall    = ~sck_s & q.sck_p;
        lead    = cpol ? fall : rise;
        trail   = cpol ? rise : fall;
        active  = en & ~ss_n_s;
        samp    = active & (cpha ? trail : lead);
        drv     = active & (cpha ? lead : trail);
        ss_fall = active & q.ss_p & ~cpha;

        d       = q;
        d.sck_p = sck_s;
        d.ss_p  = ss_n_s;
        done    = 1'b0;
        rx_data = {q.rxsh[DW-2:0], mosi_s};

        if (!active) begin
            d.cnt  = '0;
            d.busy = 1'b0;
        end else begin
            if (drv || ss_fall) begin
                d.miso  = q.shreg[DW-1];
                d.shreg = {q.shreg[DW-2:0], 1'b0};
                if (drv) begin
                    d.busy = 1'b1;
                end
            end
            if (samp) begin
                d.rxsh = rx_data;
                if (q.cnt == LAST_BIT) begin
                    done   = 1'b1;
                    d.cnt  = '0;
                    d.busy = 1'b0;
                end else begin
                    d.cnt  = q.cnt + 1'b1;
                    d.busy = 1'b1;
                end
            end
        end

        if (load) begin
            d.shreg = load_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{sck_p: 1'b0, ss_p: 1'b1, shreg: '0, rxsh: '0,
                   cnt: '0, busy: 1'b0, miso: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign miso = active & q.miso;
    assign busy = q.busy | drv | samp;

endmodule

// File: rtl/spis_regs.sv
module spis_regs
    import spis_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cpha,
    input  logic          ss_low,
    input  logic          busy,
    input  logic          done,
    input  logic [DW-1:0] rx_data,
    input  logic          bus_sel,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          load,
    output spis_flags_t   flags,
    output logic [DW-1:0] rxbuf
);

    typedef struct packed {
        spis_flags_t   fl;
        logic          armed;
        logic [DW-1:0] rxbuf;
    } rg_t;

    rg_t q, d;

    logic rd_sr, rd_dr, wr_dr, clr, collide, any_flag;
    logic [DW-1:0] sr_vec;

    always_comb begin
        rd_sr    = bus_rd & (bus_sel == SEL_STATUS);
        rd_dr    = bus_rd & (bus_sel == SEL_DATA);
        wr_dr    = bus_wr & (bus_sel == SEL_DATA);
        any_flag = q.fl.spif | q.fl.wcol | q.fl.ovr;
        clr      = rd_dr & q.armed;
        collide  = en & (busy | (~cpha & ss_low));
        load     = 1'b0;
        d        = q;

        if (rd_sr && any_flag) begin
            d.armed = 1'b1;
        end

        if (clr) begin
            d.fl    = '0;
            d.armed = 1'b0;
        end

        if (wr_dr && !(q.fl.spif && !q.armed)) begin
            if (collide) begin
                d.fl.wcol = 1'b1;
            end else begin
                load = 1'b1;
                if (q.armed) begin
                    d.fl.wcol = 1'b0;
                end
            end
        end

        if (done) begin
            if (d.fl.spif) begin
                d.fl.ovr = 1'b1;
            end else begin
                d.fl.spif = 1'b1;
                d.rxbuf   = rx_data;
            end
        end

        sr_vec        = '0;
        sr_vec[DW-1]  = q.fl.spif;
        sr_vec[DW-2]  = q.fl.wcol;
        sr_vec[DW-3]  = q.fl.ovr;
        bus_rdata     = (bus_sel == SEL_DATA) ? q.rxbuf : sr_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign flags = q.fl;
    assign rxbuf = q.rxbuf;

endmodule

// File: rtl/spi_slave_hs.sv
module spi_slave_hs
    import spis_pkg::*;
#(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_i,
    input  logic          ss_n_i,
    input  logic          mosi_i,
    output logic          miso_o,
    input  logic          cfg_en,
    input  logic          cfg_irq_en,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          irq_mask_i,
    input  logic          bus_sel,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o
);

    localparam int NSIG = 3;
    localparam logic [NSIG-1:0] SYNC_RST = 3'b010;

    logic [NSIG-1:0] pins_s;
    logic            sck_s, ss_n_s, mosi_s;
    logic            sh_busy, sh_done, sh_load;
    logic [DW-1:0]   sh_rx;
    spis_flags_t     st_flags;
    logic            st_spif, st_wcol, st_ovr;
    logic [DW-1:0]   st_rxbuf;

    spis_sync #(.W(NSIG), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sck_i, ss_n_i, mosi_i}),
        .dout (pins_s)
    );

    assign {sck_s, ss_n_s, mosi_s} = pins_s;

    spis_shift #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_en),
        .cpol     (cfg_cpol),
        .cpha     (cfg_cpha),
        .sck_s    (sck_s),
        .ss_n_s   (ss_n_s),
        .mosi_s   (mosi_s),
        .load     (sh_load),
        .load_data(bus_wdata),
        .miso     (miso_o),
        .busy     (sh_busy),
        .done     (sh_done),
        .rx_data  (sh_rx)
    );

    spis_regs #(.DW(DW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_en),
        .cpha     (cfg_cpha),
        .ss_low   (~ss_n_s),
        .busy     (sh_busy),
        .done     (sh_done),
        .rx_data  (sh_rx),
        .bus_sel  (bus_sel),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .load     (sh_load),
        .flags    (st_flags),
        .rxbuf    (st_rxbuf)
    );

    assign st_spif = st_flags.spif;
    assign st_wcol = st_flags.wcol;
    assign st_ovr  = st_flags.ovr;
    assign irq_o   = st_spif & cfg_irq_en & ~irq_mask_i;

endmodule

// File: rtl/spis_checker.sv
module spis_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_rd,
    input logic          bus_wr,
    input logic          cfg_en,
    input logic          cfg_irq_en,
    input logic          irq_mask_i,
    input logic          irq_o,
    input logic          spif,
    input logic          wcol,
    input logic          ovr,
    input logic [DW-1:0] rxbuf
);

    // R5: flag survives any cycle without a data read
    p_spif_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (spif && !(bus_rd && bus_sel)) |=> spif);

    // R7: buffer is frozen while the flag is set and unread
    p_buf_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spif && !(bus_rd && bus_sel)) |=> $stable(rxbuf));

    // R7: overrun only arises on top of a pending flag
    p_ovr_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(spif));

    // R8: collision only arises from a data write
    p_wcol_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wcol) |-> $past(bus_wr && bus_sel));

    // R9: request only with enable, no mask and a pending flag
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cfg_irq_en && !irq_mask_i && spif));

    // R10: completion only while enabled
    p_spif_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spif) |-> $past(cfg_en));

endmodule

bind spi_slave_hs spis_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .cfg_en    (cfg_en),
    .cfg_irq_en(cfg_irq_en),
    .irq_mask_i(irq_mask_i),
    .irq_o     (irq_o),
    .spif      (st_spif),
    .wcol      (st_wcol),
    .ovr       (st_ovr),
    .rxbuf     (st_rxbuf)
);

// File: tb/spi_slave_hs_tb.sv
`timescale 1ns/1ps
module spi_slave_hs_tb;

    localparam int HALF = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck_i = 1'b0, ss_n_i = 1'b1, mosi_i = 1'b0;
    logic       miso_o;
    logic       cfg_en = 1'b1, cfg_irq_en = 1'b1, cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic       irq_mask_i = 1'b0;
    logic       bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] exp_q[$];
    logic [7:0] act_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    spi_slave_hs u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ss_n_i(ss_n_i), .mosi_i(mosi_i),
        .miso_o(miso_o), .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .irq_mask_i(irq_mask_i),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] v);
        @(negedge clk);
        bus_sel = sel; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [7:0] v);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: pushes the expected MISO byte, plays the master, pushes what it saw
    task automatic spi_xfer(input string req, input logic [7:0] mo, input logic [7:0] exp_mi);
        logic [7:0] cap;
        exp_q.push_back(exp_mi);
        tag_q.push_back(req);
        cap = 8'h00;
        ss_n_i = 1'b0;
        #(HALF);
        for (int i = 7; i >= 0; i--) begin
            if (!cfg_cpha) begin
                mosi_i = mo[i];
                #(HALF);
                sck_i = ~cfg_cpol;
                cap[i] = miso_o;
                #(HALF);
                sck_i = cfg_cpol;
            end else begin
                sck_i = ~cfg_cpol;
                mosi_i = mo[i];
                #(HALF);
                sck_i = cfg_cpol;
                cap[i] = miso_o;
                #(HALF);
            end
        end
        #(HALF);
        ss_n_i = 1'b1;
        #(HALF);
        act_q.push_back(cap);
    endtask

    // monitor: pops and compares
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                chk(tag_q.pop_front(), act_q.pop_front(), exp_q.pop_front());
            end
        end
    end

    initial begin
        #(1_000_000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        bus_read(1'b0, v); chk("R1 status", v, 8'h00);
        bus_read(1'b1, v); chk("R1 data", v, 8'h00);
        chk("R1 irq", {7'd0, irq_o}, 8'h00);
        chk("R1 miso", {7'd0, miso_o}, 8'h00);

        // R2/R3 mode 0 transfer
        bus_write(1'b1, 8'hA5);
        spi_xfer("R3 miso mode0", 8'h3C, 8'hA5);
        bus_read(1'b0, v); chk("R2 flag set", v, 8'h80);
        chk("R9 irq on", {7'd0, irq_o}, 8'h01);
        irq_mask_i = 1'b1; #1;
        chk("R9 masked", {7'd0, irq_o}, 8'h00);
        irq_mask_i = 1'b0; cfg_irq_en = 1'b0; #1;
        chk("R9 disabled", {7'd0, irq_o}, 8'h00);
        cfg_irq_en = 1'b1;
        // R5 sequence: status read above armed it; fresh case below
        bus_read(1'b1, v); chk("R2 rx byte", v, 8'h3C);
        bus_read(1'b0, v); chk("R5 cleared", v, 8'h00);

        // R5 bare data read leaves flag; R6 blocked write
        bus_write(1'b1, 8'h11);
        spi_xfer("R3 miso second", 8'h5A, 8'h11);
        bus_read(1'b1, v); chk("R2 rx second", v, 8'h5A);
        bus_read(1'b0, v); chk("R5 flag kept", v, 8'h80);
        bus_read(1'b1, v);
        bus_read(1'b0, v); chk("R5 cleared again", v, 8'h00);
        bus_write(1'b1, 8'h22);
        spi_xfer("R3 miso third", 8'h99, 8'h22);
        bus_write(1'b1, 8'h77);
        // R7 overrun: flag still set, next byte arrives
        spi_xfer("R6 blocked write", 8'hE7, 8'h00);
        bus_read(1'b0, v); chk("R7 overrun bit", v, 8'hA0);
        bus_read(1'b1, v); chk("R7 buffer kept", v, 8'h99);
        bus_read(1'b0, v); chk("R7 overrun cleared", v, 8'h00);

        // R8 collision: phase 0, select low, write
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        bus_write(1'b1, 8'h44);
        ss_n_i = 1'b1;
        repeat (6) @(negedge clk);
        bus_read(1'b0, v); chk("R8 collision bit", v, 8'h40);
        bus_read(1'b1, v);
        bus_read(1'b0, v); chk("R8 collision cleared", v, 8'h00);
        spi_xfer("R8 write discarded", 8'h12, 8'h00);
        bus_read(1'b0, v);
        bus_read(1'b1, v); chk("R2 rx after collision", v, 8'h12);

        // R8 collision during active shift in phase 1
        cfg_cpha = 1'b1;
        #(HALF);
        fork
            spi_xfer("R4 mode1 under collision", 8'h0F, 8'h00);
            begin
                #(HALF * 6);
                bus_write(1'b1, 8'hFF);
            end
        join
        bus_read(1'b0, v); chk("R8 active shift collision", v, 8'hC0);
        bus_read(1'b1, v); chk("R4 rx mode1", v, 8'h0F);

        // R4 remaining modes
        for (int m = 1; m < 4; m++) begin
            cfg_cpha = m[0];
            cfg_cpol = m[1];
            sck_i = cfg_cpol;
            #(HALF);
            bus_write(1'b1, 8'hC3 ^ 8'(m));
            spi_xfer("R4 miso mode", 8'h81 + 8'(m), 8'hC3 ^ 8'(m));
            bus_read(1'b0, v); chk("R4 flag", v, 8'h80);
            bus_read(1'b1, v); chk("R4 rx", v, 8'h81 + 8'(m));
        end

        // R10 disabled block ignores the serial clock
        cfg_cpha = 1'b0; cfg_cpol = 1'b0; sck_i = 1'b0;
        #(HALF);
        bus_write(1'b1, 8'hAA);
        cfg_en = 1'b0;
        spi_xfer("R10 miso low", 8'h6E, 8'h00);
        bus_read(1'b0, v); chk("R10 no flag", v, 8'h00);
        chk("R10 no irq", {7'd0, irq_o}, 8'h00);
        cfg_en = 1'b1;

        repeat (4) @(negedge clk);
        while (act_q.size() > 0) @(negedge clk);
        summary();
    end

endmodule